// File: doc/BRIEF.md
# I2C Configuration Register Slave

This block is the serial configuration port of a clock synthesiser. It listens on a two-wire I2C bus as a slave and holds eight 8-bit configuration registers. It presents all 64 register bits in parallel to the rest of the chip. SCL and SDA are sampled with the system clock through a two-flop synchroniser. START, repeated START and STOP are found in that clock domain. SDA is driven open-drain: the `sda_oe` output pulls the line low when high.

A master addresses the block with a 7-bit device address. The upper five bits are fixed and the lower two come from strap inputs. In a write transaction the first byte after the address loads the register pointer, and each following byte is written at the pointer, which then advances. To read, the master sets the pointer the same way, issues a repeated START and resends the address with the read bit. The block then sends bytes from the pointer onward until the master withholds its acknowledge. The pointer wraps modulo the register count in both directions. A written byte takes effect at its acknowledge, not at STOP.

Top module: `cfgreg_i2c_slave`

## Requirements
- R1: After reset every register bit and `cfg_bits` is zero and `sda_oe` is low.
- R2: The block acknowledges only an address byte whose upper seven bits equal 1,0,1,1,0 followed by `addr_sel[1]`, `addr_sel[0]`. The byte's LSB is 0 for write and 1 for read. Any other address, including the general call 0x00, gets no acknowledge and changes no register.
- R3: In a write, the first byte after the address loads the pointer from its low three bits. Each later byte is written to the register at the pointer, and the pointer then advances by one.
- R4: The pointer wraps from 7 to 0 on writes and on reads, so a burst longer than eight bytes overwrites from the start.
- R5: A written byte appears on `cfg_bits[8k+7:8k]` for register k when the block drives its acknowledge, before any STOP.
- R6: A data byte cut off by STOP or by repeated START before its eighth bit leaves every register unchanged.
- R7: After a repeated START and a read address, the block sends the register at the pointer MSB first, then the following registers, advancing the pointer after each byte.
- R8: When the master does not acknowledge a read byte, the block releases SDA and drives it no more until the next START.
- R9: `sda_oe` changes only while SCL is low.
- R10: Registers read back exactly as written for any value, all-ones included, and no register value affects the serial interface.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the pad |
| sda_i | input | 1 | Serial data line as seen on the pad |
| sda_oe | output | 1 | High pulls SDA low (open-drain) |
| addr_sel | input | 2 | Strap bits for the two low address bits |
| cfg_bits | output | 64 | All registers in parallel, register k in bits 8k+7..8k |

## Verification
The bench builds the block with its default parameters: eight registers and the fixed upper address 1,0,1,1,0. With eight registers, a burst of nine or more bytes reaches the wrap of the pointer in both directions. The straps are changed between transactions, so both the matching address and a one-bit-off address can be tried on every strap value. A bit period of 32 system clocks leaves room for the synchroniser latency inside each SCL low phase. This makes the rule on when SDA may change checkable on the raw bus lines.

// File: rtl/cfgreg_i2c_slave.sv
module cfgreg_i2c_slave #(
  parameter logic [4:0] DEV_ID_HI = 5'b10110,
  parameter int NUM_REGS = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_i,
  input  logic                    sda_i,
  output logic                    sda_oe,
  input  logic [1:0]              addr_sel,
  output logic [NUM_REGS*8-1:0]   cfg_bits
);
  localparam int PTR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_REGS - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ACK_A, S_PTR, S_ACK_P, S_WR, S_ACK_W, S_RD, S_RACK
  } st_t;

  st_t              state;
  logic [1:0]       scl_q, sda_q;
  logic             scl_d, sda_d;
  logic [7:0]       shreg, txsh;
  logic [3:0]       cnt;
  logic             rw;
  logic [PTR_W-1:0] ptr;
  logic [7:0]       regs [NUM_REGS];

  wire scl_s    = scl_q[1];
  wire sda_s    = sda_q[1];
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire start_c  = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c   = scl_s & scl_d & ~sda_d & sda_s;
  wire addr_hit = (shreg[7:1] == {DEV_ID_HI, addr_sel});

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q  <= 2'b11;
      sda_q  <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
      state  <= S_IDLE;
      shreg  <= '0;
      txsh   <= '0;
      cnt    <= '0;
      rw     <= 1'b0;
      ptr    <= '0;
      sda_oe <= 1'b0;
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else begin
      scl_q <= {scl_q[0], scl_i};
      sda_q <= {sda_q[0], sda_i};
      scl_d <= scl_s;
      sda_d <= sda_s;
      if (start_c) begin
        state  <= S_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        state  <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          S_ADDR, S_PTR, S_WR: begin
            if (scl_rise) begin
              shreg <= {shreg[6:0], sda_s};
              cnt   <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              if (state == S_ADDR) begin
                if (addr_hit) begin
                  rw     <= shreg[0];
                  sda_oe <= 1'b1;
                  state  <= S_ACK_A;
                end else begin
                  state <= S_IDLE;
                end
              end else if (state == S_PTR) begin
                ptr    <= shreg[PTR_W-1:0];
                sda_oe <= 1'b1;
                state  <= S_ACK_P;
              end else begin
                regs[ptr] <= shreg;
                ptr       <= ptr_next(ptr);
                sda_oe    <= 1'b1;
                state     <= S_ACK_W;
              end
            end
          end
          S_ACK_A, S_ACK_P, S_ACK_W: begin
            if (scl_fall) begin
              cnt <= '0;
              if (state == S_ACK_A && rw) begin
                sda_oe <= ~regs[ptr][7];
                txsh   <= {regs[ptr][6:0], 1'b0};
                cnt    <= 4'd1;
                state  <= S_RD;
              end else begin
                sda_oe <= 1'b0;
                state  <= (state == S_ACK_A) ? S_PTR : S_WR;
              end
            end
          end
          S_RD: begin
            if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
                ptr    <= ptr_next(ptr);
                state  <= S_RACK;
              end else begin
                sda_oe <= ~txsh[7];
                txsh   <= {txsh[6:0], 1'b0};
                cnt    <= cnt + 4'd1;
              end
            end
          end
          S_RACK: begin
            if (scl_rise && sda_s) begin
              state <= S_IDLE;
            end else if (scl_fall) begin
              sda_oe <= ~regs[ptr][7];
              txsh   <= {regs[ptr][6:0], 1'b0};
              cnt    <= 4'd1;
              state  <= S_RD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
    assign cfg_bits[g*8 +: 8] = regs[g];
  end

  p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (cfg_bits == '0 && !sda_oe));

  p_addr_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ACK_A && $past(state) == S_ADDR) |->
      ($past(shreg[7:1]) == {DEV_ID_HI, $past(addr_sel)}));

  p_commit_on_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_bits != $past(cfg_bits)) |-> (sda_oe && !$past(sda_oe)));

  p_release_rx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE || state == S_RACK || state == S_ADDR ||
     state == S_PTR || state == S_WR) |-> !sda_oe);

  p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_s));
endmodule

// File: tb/cfgreg_i2c_slave_tb_top.sv
module cfgreg_i2c_slave_tb_top;
  localparam int Q = 8;
  localparam logic [4:0] ID = 5'b10110;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] asel = 2'b00;
  logic sda_oe;
  logic [63:0] cfg_bits;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0, fails = 0, r9_bad = 0;
  logic [7:0] expr [8];
  logic [7:0] wbuf [16];

  always #2 clk = ~clk;

  cfgreg_i2c_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .addr_sel(asel), .cfg_bits(cfg_bits));

  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_oe != oe_prev && scl_m) r9_bad++;
    oe_prev <= sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(2*Q);
  endtask

  task automatic wbit(input logic b);
    sda_m = b; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); b = sda_line; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(b);
    ack = ~b;
  endtask

  task automatic rbyte(output logic [7:0] d, input logic mack);
    for (int i = 7; i >= 0; i--) rbit(d[i]);
    wbit(~mack);
  endtask

  function automatic logic [7:0] dev(input logic rd);
    return {ID, asel, rd};
  endfunction

  function automatic logic [63:0] model();
    logic [63:0] m;
    for (int k = 0; k < 8; k++) m[k*8 +: 8] = expr[k];
    return m;
  endfunction

  task automatic set_ptr(input logic [7:0] p);
    logic a;
    i2c_start();
    wbyte(dev(1'b0), a); chk(a, "R2 write address ack", a, 1);
    wbyte(p, a);         chk(a, "R3 pointer byte ack", a, 1);
  endtask

  task automatic write_tx(input logic [7:0] p, input int n);
    logic a;
    int k;
    set_ptr(p);
    k = p[2:0];
    for (int i = 0; i < n; i++) begin
      wbyte(wbuf[i], a);
      chk(a, "R3 data ack", a, 1);
      expr[k] = wbuf[i];
      chk(cfg_bits[k*8 +: 8] == wbuf[i], "R5 byte visible at ack before stop",
          cfg_bits[k*8 +: 8], wbuf[i]);
      k = (k + 1) % 8;
    end
    i2c_stop();
    chk(cfg_bits == model(), "R4 register file after burst", 0, 0);
  endtask

  task automatic read_tx(input logic [7:0] p, input int n);
    logic a;
    logic [7:0] d;
    set_ptr(p);
    i2c_start();
    wbyte(dev(1'b1), a); chk(a, "R7 read address ack", a, 1);
    for (int i = 0; i < n; i++) begin
      rbyte(d, i != n - 1);
      chk(d == expr[(p[2:0] + i) % 8], "R7 read byte (R4 wrap)", d, expr[(p[2:0] + i) % 8]);
    end
    i2c_stop();
  endtask

  initial begin
    logic a, b;
    logic [7:0] d;
    int unsigned sd;
    bit hi;
    for (int k = 0; k < 8; k++) expr[k] = 8'h00;
    sd = $urandom(32'd4711);
    wq(5);
    chk(cfg_bits == 64'd0 && sda_oe == 1'b0, "R1 reset state", int'(cfg_bits[31:0]), 0);
    rst_n = 1'b1;
    wq(5);
    chk(cfg_bits == 64'd0 && sda_oe == 1'b0, "R1 state after release", int'(cfg_bits[31:0]), 0);

    asel = 2'b10;
    i2c_start();
    wbyte({ID, 2'b01, 1'b0}, a);
    chk(!a, "R2 wrong strap bits not acked", a, 0);
    wbyte(8'h02, a); wbyte(8'hFF, a);
    i2c_stop();
    i2c_start();
    wbyte(8'h00, a);
    chk(!a, "R2 general call not acked", a, 0);
    wbyte(8'h01, a); wbyte(8'hFF, a);
    i2c_stop();
    chk(cfg_bits == 64'd0, "R2 no register change on mismatch", int'(cfg_bits[31:0]), 0);

    wbuf[0] = 8'h5A;
    write_tx(8'h03, 1);
    chk(cfg_bits[31:24] == 8'h5A, "R3 single write at pointer 3", cfg_bits[31:24], 8'h5A);

    for (int i = 0; i < 10; i++) wbuf[i] = 8'h10 + 8'(i);
    write_tx(8'h06, 10);
    chk(cfg_bits[7:0] == 8'h12 && cfg_bits[15:8] == 8'h13, "R4 write wrap 7 to 0",
        cfg_bits[15:0], 16'h1312);
    wbuf[0] = 8'hC3;
    write_tx(8'h0D, 1);
    chk(cfg_bits[47:40] == 8'hC3, "R3 pointer uses low three bits", cfg_bits[47:40], 8'hC3);

    set_ptr(8'h02);
    for (int i = 0; i < 4; i++) wbit(i[0]);
    i2c_stop();
    chk(cfg_bits == model(), "R6 partial byte dropped on stop", int'(cfg_bits[31:0]), int'(model()));
    set_ptr(8'h02);
    for (int i = 0; i < 5; i++) wbit(1'b1);
    i2c_start();
    wbyte(dev(1'b1), a);
    chk(a, "R7 read address ack after repeated start", a, 1);
    rbyte(d, 1'b0);
    chk(d == expr[2], "R6 partial byte dropped on repeated start", d, expr[2]);
    i2c_stop();

    read_tx(8'h03, 1);
    read_tx(8'h05, 9);

    set_ptr(8'h00);
    i2c_start();
    wbyte(dev(1'b1), a);
    rbyte(d, 1'b0);
    hi = 1'b1;
    for (int i = 0; i < 9; i++) begin
      rbit(b);
      hi = hi & b;
    end
    chk(hi && !sda_oe, "R8 released after master nack", hi, 1);
    i2c_stop();

    for (int i = 0; i < 8; i++) wbuf[i] = 8'hFF;
    write_tx(8'h00, 8);
    read_tx(8'h04, 8);
    chk(cfg_bits == {64{1'b1}}, "R10 all-ones readback", int'(cfg_bits[31:0]), -1);

    for (int t = 0; t < 12; t++) begin
      int n;
      logic [7:0] p;
      asel = 2'($urandom());
      n = 1 + int'($urandom() % 9);
      p = 8'($urandom());
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom());
      write_tx(p, n);
      read_tx(8'($urandom()), 1 + int'($urandom() % 9));
    end

    chk(r9_bad == 0, "R9 sda_oe changed while SCL high", r9_bad, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule